// File: doc/BRIEF.md
# Belief-Propagation Message Update Element

This block produces one outgoing message vector for a single pixel node of a stereo belief-propagation solver. The vector has one entry per disparity label. The smoothness cost between labels a and b is min(step·|a−b|, cap). Upstream logic adds the data cost to the incoming neighbour messages. It presents the result as a serial stream of per-label sums, one label per accepted beat, starting at label 0. The block computes the message in two passes of a min-convolution:

- An ascending pass filters the sums with a running minimum that grows by `step` per label. Its results go into a last-in-first-out stack.
- A descending pass pops the stack and applies the same recursion in the opposite direction. It then caps each value at the smallest sum plus `cap`, subtracts that smallest sum, and clips the result to the message width.

The stack has two banks used in ping-pong. The ascending pass of the next vector can run while the descending pass of the current vector is still draining. A vector takes one clock per label in each direction. All arithmetic is unsigned and saturates at the internal width.

Top module: `bp_msg_pe`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `out_valid` is 0.
- R2: For an input vector s(0..D−1), write α = min s and m(j) = min over l of (s(l) + step·|j−l|), with every sum saturating at 2^SUM_W−1. Output entry j is then min(m(j), α+cap) − α, clipped to 2^MSG_W−1.
- R3: Output entries come out in descending label order, D−1 first. `out_last` is 1 only on the beat that carries label 0.
- R4: Every output vector contains at least one entry equal to 0.
- R5: No output entry exceeds `cap`.
- R6: An entry whose normalised value is above 2^MSG_W−1 is output as 2^MSG_W−1.
- R7: When a stack bank is free, `out_valid` rises in the cycle right after the last input beat is accepted, and not earlier.
- R8: A second vector is accepted with no stall while the first vector is still held at the output. Once both banks hold vectors, `in_ready` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_msg` and `out_last` hold their values.
- R10: An accepted beat with `in_first` = 1 is taken as label 0 and discards any partial vector. The output then depends only on the restarted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_step | input | SUM_W | Cost per label of distance; held stable while vectors are in flight |
| cfg_cap | input | SUM_W | Truncation level of the smoothness cost; held stable while vectors are in flight |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be accepted |
| in_first | input | 1 | Beat carries label 0 of a new vector |
| in_sum | input | SUM_W | Data cost plus incoming messages for the current label |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_msg | output | MSG_W | Normalised message entry |
| out_last | output | 1 | Beat carries label 0, the final entry of the vector |

## Verification
A vector's first output is due one cycle after its final input beat is accepted, provided a stack bank is free. After that, one entry is due per cycle in which `out_ready` is high. The bench drives inputs and reads outputs at falling edges. It compares an entry only on a falling edge where both `out_valid` and `out_ready` are seen high, so each comparison lines up with the rising edge that consumes the entry. It checks the release cycle directly: `out_valid` must be 0 while the last beat is still waiting for its edge, and 1 at the falling edge after it. Stalls are counted by watching `in_ready` on each beat the bench offers.

// File: rtl/bp_pe_pkg.sv
// Package: shared defaults and the stack-bank state type for the
// belief-propagation message element.
// Assumes: nothing beyond IEEE 1800-2017.
package bp_pe_pkg;
    localparam int unsigned DEF_LABELS = 16;
    localparam int unsigned DEF_MSG_W  = 4;
    localparam int unsigned DEF_SUM_W  = 8;
    localparam int unsigned DEF_BANKS  = 2;

    typedef enum logic {
        BANK_EMPTY = 1'b0,
        BANK_FULL  = 1'b1
    } bank_state_e;
endpackage

// File: rtl/bp_fwd_stage.sv
// Ascending pass: f(t) = min(s(t), f(t-1)+step), with f(-1) taken as the
// saturation value. It also tracks the minimum of the sums (alpha).
// Assumes: `beat` is high only for an accepted input beat; `first` forces label 0.
module bp_fwd_stage #(
    parameter int unsigned NUM_LABELS = 16,
    parameter int unsigned SUM_W      = 8,
    localparam int unsigned IDX_W     = $clog2(NUM_LABELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             first,
    input  logic [SUM_W-1:0] sum,
    input  logic [SUM_W-1:0] step,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [SUM_W-1:0] wr_data,
    output logic             done,
    output logic [SUM_W-1:0] alpha
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LABELS - 1);
    localparam logic [SUM_W-1:0] SAT_MAX  = '1;

    logic [IDX_W-1:0] cnt_q;
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] amin_q;
    logic [IDX_W-1:0] eff_cnt;
    logic [SUM_W-1:0] prev_cost;
    logic [SUM_W-1:0] fwd_val;

    function automatic logic [SUM_W-1:0] sat_add(input logic [SUM_W-1:0] a,
                                                 input logic [SUM_W-1:0] b);
        logic [SUM_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SUM_W] ? SAT_MAX : s[SUM_W-1:0];
    endfunction

    // Label index, candidate from the previous label, and the filtered value.
    always_comb begin
        eff_cnt   = first ? '0 : cnt_q;
        prev_cost = (eff_cnt == '0) ? SAT_MAX : sat_add(acc_q, step);
        fwd_val   = (sum < prev_cost) ? sum : prev_cost;
        if (eff_cnt == '0) alpha = sum;
        else               alpha = (sum < amin_q) ? sum : amin_q;
        wr_en     = beat;
        wr_addr   = eff_cnt;
        wr_data   = fwd_val;
        done      = beat && (eff_cnt == LAST_IDX);
    end

    // Advance the recursion register, the running minimum and the label count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            acc_q  <= SAT_MAX;
            amin_q <= SAT_MAX;
        end else if (beat) begin
            acc_q  <= fwd_val;
            amin_q <= alpha;
            cnt_q  <= done ? '0 : eff_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bp_lifo_banks.sv
// Stack banks in ping-pong: each bank is filled in ascending address order and
// read back in descending order. Each bank keeps the alpha of its vector.
// Assumes: writes go only to an empty bank and releases only to a full one.
module bp_lifo_banks
    import bp_pe_pkg::*;
#(
    parameter int unsigned NUM_LABELS = 16,
    parameter int unsigned SUM_W      = 8,
    parameter int unsigned NBANKS     = 2,
    localparam int unsigned IDX_W     = $clog2(NUM_LABELS),
    localparam int unsigned SEL_W     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [SUM_W-1:0] wr_data,
    input  logic             wr_commit,
    input  logic [SUM_W-1:0] wr_alpha,
    output logic             wr_ready,
    input  logic [IDX_W-1:0] rd_addr,
    input  logic             rd_release,
    output logic             rd_avail,
    output logic [SUM_W-1:0] rd_data,
    output logic [SUM_W-1:0] rd_alpha
);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NBANKS - 1);

    logic [SUM_W-1:0] mem     [NBANKS][NUM_LABELS];
    logic [SUM_W-1:0] alpha_q [NBANKS];
    bank_state_e      state_q [NBANKS];
    logic [SEL_W-1:0] wr_sel_q;
    logic [SEL_W-1:0] rd_sel_q;

    // Stack storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_sel_q][wr_addr] <= wr_data;
    end

    // Per-bank full/empty state and stored alpha.
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[b] <= BANK_EMPTY;
                alpha_q[b] <= '0;
            end else if (wr_commit && (wr_sel_q == SEL_W'(b))) begin
                state_q[b] <= BANK_FULL;
                alpha_q[b] <= wr_alpha;
            end else if (rd_release && (rd_sel_q == SEL_W'(b))) begin
                state_q[b] <= BANK_EMPTY;
            end
        end
    end

    // Rotate the write and read bank pointers on commit and on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel_q <= '0;
            rd_sel_q <= '0;
        end else begin
            if (wr_commit)  wr_sel_q <= (wr_sel_q == SEL_LAST) ? '0 : wr_sel_q + 1'b1;
            if (rd_release) rd_sel_q <= (rd_sel_q == SEL_LAST) ? '0 : rd_sel_q + 1'b1;
        end
    end

    // Status flags and the read port.
    always_comb begin
        wr_ready = (state_q[wr_sel_q] == BANK_EMPTY);
        rd_avail = (state_q[rd_sel_q] == BANK_FULL);
        rd_data  = mem[rd_sel_q][rd_addr];
        rd_alpha = alpha_q[rd_sel_q];
    end
endmodule

// File: rtl/bp_bwd_stage.sv
// Descending pass: b(j) = min(f(j), b(j+1)+step). It caps b(j) at alpha+cap,
// subtracts alpha, clips to the message range and streams the result out.
// Assumes: SUM_W > MSG_W; the stack read port returns data in the same cycle.
module bp_bwd_stage #(
    parameter int unsigned NUM_LABELS = 16,
    parameter int unsigned SUM_W      = 8,
    parameter int unsigned MSG_W      = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_LABELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_avail,
    input  logic [SUM_W-1:0] rd_data,
    input  logic [SUM_W-1:0] rd_alpha,
    input  logic [SUM_W-1:0] step,
    input  logic [SUM_W-1:0] cap,
    input  logic             out_ready,
    output logic [IDX_W-1:0] rd_addr,
    output logic             rd_release,
    output logic             out_valid,
    output logic [MSG_W-1:0] out_msg,
    output logic             out_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LABELS - 1);
    localparam logic [SUM_W-1:0] SAT_MAX  = '1;
    localparam logic [SUM_W-1:0] MSG_MAX  = SUM_W'((1 << MSG_W) - 1);

    logic [IDX_W-1:0] cnt_q;
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] prev_cost;
    logic [SUM_W-1:0] bwd_val;
    logic [SUM_W-1:0] trunc_lvl;
    logic [SUM_W-1:0] capped;
    logic [SUM_W-1:0] norm;
    logic             fire;

    function automatic logic [SUM_W-1:0] sat_add(input logic [SUM_W-1:0] a,
                                                 input logic [SUM_W-1:0] b);
        logic [SUM_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SUM_W] ? SAT_MAX : s[SUM_W-1:0];
    endfunction

    // Pop address, recursion, truncation, normalisation and clip.
    always_comb begin
        rd_addr    = LAST_IDX - cnt_q;
        prev_cost  = (cnt_q == '0) ? SAT_MAX : sat_add(acc_q, step);
        bwd_val    = (rd_data < prev_cost) ? rd_data : prev_cost;
        trunc_lvl  = sat_add(rd_alpha, cap);
        capped     = (bwd_val < trunc_lvl) ? bwd_val : trunc_lvl;
        norm       = capped - rd_alpha;
        out_valid  = rd_avail;
        out_msg    = (norm > MSG_MAX) ? MSG_MAX[MSG_W-1:0] : norm[MSG_W-1:0];
        out_last   = rd_avail && (cnt_q == LAST_IDX);
        fire       = rd_avail && out_ready;
        rd_release = fire && (cnt_q == LAST_IDX);
    end

    // Advance the backward recursion register and pop count on each output beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= SAT_MAX;
        end else if (fire) begin
            acc_q <= bwd_val;
            cnt_q <= rd_release ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bp_msg_pe.sv
// Top: belief-propagation message update element. Sums stream in one label per
// beat; the normalised message streams out in descending label order.
// Assumes: cfg_step and cfg_cap are stable while any vector is in flight.
module bp_msg_pe
    import bp_pe_pkg::*;
#(
    parameter int unsigned NUM_LABELS = DEF_LABELS,
    parameter int unsigned MSG_W      = DEF_MSG_W,
    parameter int unsigned SUM_W      = DEF_SUM_W,
    parameter int unsigned NBANKS     = DEF_BANKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] cfg_step,
    input  logic [SUM_W-1:0] cfg_cap,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_first,
    input  logic [SUM_W-1:0] in_sum,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [MSG_W-1:0] out_msg,
    output logic             out_last
);
    localparam int unsigned IDX_W = $clog2(NUM_LABELS);

    logic             beat;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [SUM_W-1:0] wr_data;
    logic             fwd_done;
    logic [SUM_W-1:0] fwd_alpha;
    logic             wr_ready;
    logic [IDX_W-1:0] rd_addr;
    logic             rd_release;
    logic             rd_avail;
    logic [SUM_W-1:0] rd_data;
    logic [SUM_W-1:0] rd_alpha;

    // Input handshake: a beat is taken only when the write bank is free.
    always_comb begin
        in_ready = wr_ready;
        beat     = in_valid && wr_ready;
    end

    bp_fwd_stage #(.NUM_LABELS(NUM_LABELS), .SUM_W(SUM_W)) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (beat),
        .first   (in_first),
        .sum     (in_sum),
        .step    (cfg_step),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .done    (fwd_done),
        .alpha   (fwd_alpha)
    );

    bp_lifo_banks #(.NUM_LABELS(NUM_LABELS), .SUM_W(SUM_W), .NBANKS(NBANKS)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_commit  (fwd_done),
        .wr_alpha   (fwd_alpha),
        .wr_ready   (wr_ready),
        .rd_addr    (rd_addr),
        .rd_release (rd_release),
        .rd_avail   (rd_avail),
        .rd_data    (rd_data),
        .rd_alpha   (rd_alpha)
    );

    bp_bwd_stage #(.NUM_LABELS(NUM_LABELS), .SUM_W(SUM_W), .MSG_W(MSG_W)) u_bwd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_avail   (rd_avail),
        .rd_data    (rd_data),
        .rd_alpha   (rd_alpha),
        .step       (cfg_step),
        .cap        (cfg_cap),
        .out_ready  (out_ready),
        .rd_addr    (rd_addr),
        .rd_release (rd_release),
        .out_valid  (out_valid),
        .out_msg    (out_msg),
        .out_last   (out_last)
    );
endmodule

// File: rtl/bp_msg_pe_chk.sv
// Checker: temporal properties of the message element's ports, bound to the top.
// Assumes: cfg_cap is stable while output beats are present.
module bp_msg_pe_chk #(
    parameter int unsigned NUM_LABELS = 16,
    parameter int unsigned MSG_W      = 4,
    parameter int unsigned SUM_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SUM_W-1:0] cfg_cap,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [MSG_W-1:0] out_msg,
    input logic             out_last
);
    localparam int unsigned IDX_W = $clog2(NUM_LABELS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LABELS - 1);

    logic [IDX_W-1:0] beat_cnt;
    logic             zero_seen;

    // Count output beats within a vector and note whether a zero was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt  <= '0;
            zero_seen <= 1'b0;
        end else if (out_valid && out_ready) begin
            beat_cnt  <= out_last ? '0 : beat_cnt + 1'b1;
            zero_seen <= out_last ? 1'b0 : (zero_seen || (out_msg == '0));
        end
    end

    assert_last_position_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (out_last == (beat_cnt == LAST_IDX)));

    assert_has_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |-> (zero_seen || (out_msg == '0)));

    assert_within_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({{SUM_W{1'b0}}, out_msg} <= {{MSG_W{1'b0}}, cfg_cap}));

    assert_stall_only_when_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> out_valid);

    assert_hold_under_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_msg) && $stable(out_last)));
endmodule

bind bp_msg_pe bp_msg_pe_chk #(
    .NUM_LABELS (NUM_LABELS),
    .MSG_W      (MSG_W),
    .SUM_W      (SUM_W)
) u_chk (.*);

// File: tb/test_bp_msg_pe.sv
module test_bp_msg_pe;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int MW = 4;
    localparam int SW = 8;
    localparam int MAXV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] cfg_step = '0;
    logic [SW-1:0] cfg_cap = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_first = 1'b0;
    logic [SW-1:0] in_sum = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [MW-1:0] out_msg;
    logic          out_last;

    int checks = 0;
    int errors = 0;
    int stalls = 0;
    int vecs [MAXV][NL];
    int lcg = 12345;

    bp_msg_pe #(.NUM_LABELS(NL), .MSG_W(MW), .SUM_W(SW)) i_bp_msg_pe (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_rand();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return (lcg >>> 8) & 255;
    endfunction

    // Reference entry for label j of vector v, computed from R2.
    function automatic int ref_entry(input int v, input int j);
        int alpha = 255;
        int m = 255;
        int t, r;
        for (int l = 0; l < NL; l++) begin
            if (vecs[v][l] < alpha) alpha = vecs[v][l];
            t = vecs[v][l] + int'(cfg_step) * ((j > l) ? j - l : l - j);
            if (t > 255) t = 255;
            if (t < m) m = t;
        end
        t = alpha + int'(cfg_cap);
        if (t > 255) t = 255;
        r = ((m < t) ? m : t) - alpha;
        return (r > 15) ? 15 : r;
    endfunction

    function automatic void fill_vec(input int v, input int pat);
        for (int l = 0; l < NL; l++) begin
            case (pat)
                0: vecs[v][l] = 0;
                1: vecs[v][l] = l * 9;
                2: vecs[v][l] = (l > 7) ? (l - 7) * 20 : (7 - l) * 20;
                3: vecs[v][l] = 255;
                4: vecs[v][l] = (l == 11) ? 3 : 200;
                default: vecs[v][l] = next_rand();
            endcase
        end
    endfunction

    // Offer vector v; returns after its last beat is driven with in_ready high.
    task automatic send_vec(input int v, input int nbeats);
        for (int l = 0; l < nbeats; l++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (l == 0);
            in_sum   = SW'(vecs[v][l]);
            #1;
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
                #1;
            end
        end
    endtask

    // Collect and compare vectors first..first+count-1; mode 1 throttles out_ready.
    task automatic drain(input int first, input int count, input int mode);
        int k = 0;
        int cyc = 0;
        while (k < count * NL) begin
            @(negedge clk);
            out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            cyc++;
            #1;
            if (out_valid && out_ready) begin
                int v = first + k / NL;
                int lab = NL - 1 - (k % NL);
                int e = ref_entry(v, lab);
                check(int'(out_msg) == e, "R2 entry value", int'(out_msg), e);
                check(out_last == (lab == 0), "R3 last flag", int'(out_last), int'(lab == 0));
                if (e == 15 && int'(cfg_cap) > 15) check(out_msg == 4'd15, "R6 clip", int'(out_msg), 15);
                k++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // R7: release cycle of the first output.
        cfg_step = 8'd2; cfg_cap = 8'd7;
        fill_vec(0, 1);
        send_vec(0, NL);
        check(out_valid == 1'b0, "R7 no output before last beat taken", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid == 1'b1, "R7 output one cycle after last beat", int'(out_valid), 1);
        drain(0, 1, 0);

        // R8 and R9: fill both banks while the output is held.
        cfg_step = 8'd3; cfg_cap = 8'd12;
        fill_vec(0, 2);
        fill_vec(1, 5);
        send_vec(0, NL);
        stalls = 0;
        send_vec(1, NL);
        check(stalls == 0, "R8 second vector without stall", stalls, 0);
        @(negedge clk);
        in_valid = 1'b1; in_first = 1'b1; in_sum = '0;
        #1;
        check(in_ready == 1'b0, "R8 both banks full", int'(in_ready), 0);
        in_valid = 1'b0;
        begin
            logic [MW-1:0] held;
            held = out_msg;
            repeat (3) @(negedge clk);
            #1;
            check(out_valid == 1'b1, "R9 valid held", int'(out_valid), 1);
            check(out_msg == held, "R9 entry held", int'(out_msg), int'(held));
        end
        drain(0, 2, 1);

        // R10: a partial vector is discarded by a restart.
        cfg_step = 8'd1; cfg_cap = 8'd9;
        fill_vec(1, 5);
        fill_vec(0, 4);
        send_vec(1, 5);
        send_vec(0, NL);
        @(negedge clk);
        in_valid = 1'b0;
        drain(0, 1, 0);

        // Sweep of step and cap over several patterns (R2, R4, R5, R6).
        for (int si = 0; si < 5; si++) begin
            for (int ci = 0; ci < 6; ci++) begin
                int steps[5] = '{0, 1, 2, 5, 15};
                int caps[6]  = '{0, 3, 7, 15, 40, 255};
                cfg_step = SW'(steps[si]);
                cfg_cap  = SW'(caps[ci]);
                for (int v = 0; v < MAXV; v++) fill_vec(v, v);
                fork
                    begin
                        for (int v = 0; v < MAXV; v++) send_vec(v, NL);
                        @(negedge clk);
                        in_valid = 1'b0;
                    end
                    drain(0, MAXV, (si + ci) % 2);
                join
                check(out_valid == 1'b0, "R2 no extra output after sweep", int'(out_valid), 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule